// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor and a slower memory. It keeps one 32-bit word per line in a direct-mapped array, with a valid flag and a dirty flag on every line. Loads and stores that hit are answered from the array alone. A store that hits changes only the cached copy and marks the line dirty, so memory holds stale data until that line is evicted. On a miss the controller first writes the old line back to memory, but only if it is both valid and dirty. It then fetches the requested word. A store miss also fetches the word first (allocate-on-write) and then merges the store data into the line.

The processor offers a request by raising `cpu_req_valid` while `cpu_ready` is high. The controller accepts it on that clock edge, drops `cpu_ready` at once and keeps it low until the answer has been given. The answer is a one-cycle pulse on `cpu_resp_valid`, with the load data on `cpu_rdata`. The memory side is a request/acknowledge pair. `mem_rd` or `mem_wr` stays high with a steady address and data until the memory raises `mem_ready` for one cycle, so the memory may take any number of cycles to answer.

The controller has five states:
- IDLE: accepts a request, then goes to COMPARE.
- COMPARE: looks up the line. On a hit it goes to RESPOND. On a miss whose victim line is valid and dirty it goes to WRITEBACK. On any other miss it goes to REFILL.
- WRITEBACK: waits for `mem_ready`, then goes to REFILL.
- REFILL: waits for `mem_ready` and writes the line, then goes to RESPOND.
- RESPOND: gives the answer, then goes back to IDLE.

Top module: `wb_cache_ctrl`

## Requirements
- R1: Reset clears every valid and dirty flag. After reset, `cpu_ready` is 1, `mem_rd`, `mem_wr` and `cpu_resp_valid` are 0, and the first access to any address misses.
- R2: A load that hits causes no memory request. `cpu_resp_valid` is high in the second cycle after the accepting edge, and `cpu_rdata` carries the word last stored to that address, or the word last read from memory for it.
- R3: A store that hits causes no memory request. It updates the cached word and sets the line dirty, and memory keeps its old value.
- R4: A load miss with a clean or invalid victim makes exactly one memory read, at the word-aligned request address. It returns the memory word, and the refilled line is left clean.
- R5: A store miss reads the line from memory before anything else is done for it. It then holds the store data and is dirty, so a later eviction writes that data back.
- R6: A miss whose victim is valid and dirty makes a memory write first, with the victim's address (old tag, same index, offset 0) and its data. The read of the new line follows. A miss whose victim is clean or invalid makes no memory write.
- R7: The address splits into the byte offset [1:0], which is ignored; the line index [11:2]; and the tag [31:12]. Addresses that differ only in their offset share one line. Index 0 and index 1023 are separate lines.
- R8: `cpu_ready` is low from the accepting edge until the response cycle has passed. `mem_rd` and `mem_wr` are never high together. A memory request keeps its address and data steady until `mem_ready`. No memory request is made in the cycle right after acceptance.
- R9: `cpu_resp_valid` is high for exactly one cycle per access, and `cpu_ready` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor offers an access |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address of the access |
| cpu_req_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Controller is idle and can take an access |
| cpu_resp_valid | output | 1 | One-cycle pulse: access complete |
| cpu_rdata | output | 32 | Load data, valid with `cpu_resp_valid` |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Data for a memory write |
| mem_rdata | input | 32 | Data returned by memory |
| mem_ready | input | 1 | Memory completes the pending request |

## Verification
A wrong tag or valid flag shows up on the very access that uses the line. There is either a memory read on what should have been a hit, which also stretches the latency past two cycles, or load data that does not match.

A dirty flag that is wrongly set or cleared stays hidden until that line is evicted. At that point it appears as an extra memory write or a missing one, with the victim's address and data. For that reason the bench keeps revisiting a few conflicting lines, so every dirty flag is tested by a later eviction within a few accesses.

Sequencing faults, such as a read issued before the write-back or a ready signal released early, are visible within the same access.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } wbc_state_e;
endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
    parameter int LINES  = 1024,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic              lk_dirty,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty
);
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;

    // Flags are reset; tag and data arrays are not.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[lk_idx] <= 1'b1;
            dirty_q[lk_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[lk_idx]  <= wr_tag;
            data_mem[lk_idx] <= wr_data;
        end
    end

    always_comb begin
        lk_valid = valid_q[lk_idx];
        lk_dirty = dirty_q[lk_idx];
        lk_tag   = tag_mem[lk_idx];
        lk_data  = data_mem[lk_idx];
    end
endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 2,
    parameter int TAG_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_valid,
    input  logic              lk_dirty,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_dirty
);
    wbc_state_e        state_q, state_d;
    logic              we_q;
    logic [TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;
    logic              hit;

    assign accept = (state_q == ST_IDLE) && cpu_req_valid;
    assign hit    = lk_valid && (lk_tag == tag_q);
    assign lk_idx = idx_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (hit)                     state_d = ST_RESPOND;
                else if (lk_valid && lk_dirty) state_d = ST_WRITEBACK;
                else                         state_d = ST_REFILL;
            end
            ST_WRITEBACK: if (mem_ready) state_d = ST_REFILL;
            ST_REFILL:    if (mem_ready) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            tag_q   <= '0;
            idx_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                we_q    <= cpu_req_we;
                tag_q   <= cpu_req_addr[ADDR_W-1 -: TAG_W];
                idx_q   <= cpu_req_addr[OFF_W +: IDX_W];
                wdata_q <= cpu_req_wdata;
            end
            if (state_q == ST_COMPARE && hit)
                rdata_q <= we_q ? wdata_q : lk_data;
            else if (state_q == ST_REFILL && mem_ready)
                rdata_q <= we_q ? wdata_q : mem_rdata;
        end
    end

    assign cpu_rdata = rdata_q;

    // Outputs per state
    always_comb begin
        cpu_ready      = 1'b0;
        cpu_resp_valid = 1'b0;
        mem_rd         = 1'b0;
        mem_wr         = 1'b0;
        mem_addr       = '0;
        mem_wdata      = '0;
        wr_en          = 1'b0;
        wr_tag         = tag_q;
        wr_data        = wdata_q;
        wr_dirty       = 1'b0;
        unique case (state_q)
            ST_IDLE:    cpu_ready = 1'b1;
            ST_COMPARE: begin
                if (hit && we_q) begin
                    wr_en    = 1'b1;
                    wr_dirty = 1'b1;
                end
            end
            ST_WRITEBACK: begin
                mem_wr    = 1'b1;
                mem_addr  = {lk_tag, idx_q, {OFF_W{1'b0}}};
                mem_wdata = lk_data;
            end
            ST_REFILL: begin
                mem_rd   = 1'b1;
                mem_addr = {tag_q, idx_q, {OFF_W{1'b0}}};
                if (mem_ready) begin
                    wr_en    = 1'b1;
                    wr_data  = we_q ? wdata_q : mem_rdata;
                    wr_dirty = we_q;
                end
            end
            ST_RESPOND: cpu_resp_valid = 1'b1;
            default:    cpu_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINES      = 1024,
    parameter int LINE_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid, lk_dirty;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              wr_en, wr_dirty;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    wbc_line_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx),
        .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag), .lk_data(lk_data),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data), .wr_dirty(wr_dirty)
    );

    wbc_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
        .lk_tag(lk_tag), .lk_data(lk_data),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data), .wr_dirty(wr_dirty)
    );
endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_ready,
    input logic              cpu_resp_valid,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_req_valid |=> !cpu_ready && !mem_rd && !mem_wr);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_ready |=> mem_rd && $stable(mem_addr));

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_ready |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

    // R6
    wb_then_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && mem_ready |=> mem_rd && !mem_wr);

    // R4
    refill_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && mem_ready |=> cpu_resp_valid);

    // R9
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid && cpu_ready);

    // R8
    resp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> !cpu_ready);
endmodule

bind wb_cache_ctrl wbc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_ready(cpu_ready),
    .cpu_resp_valid(cpu_resp_valid), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/wb_cache_ctrl_tb.sv
`timescale 1ns/1ps
module wb_cache_ctrl_tb;
    localparam int LINES = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_we = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_ready, cpu_resp_valid;
    logic [31:0] cpu_rdata;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2.5 clk = ~clk;

    wb_cache_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int total = 0;
    int bad   = 0;

    // Environment memory and event log
    logic [31:0] bmem [int unsigned];
    int          ev_n = 0;
    bit          ev_w [8];
    logic [31:0] ev_a [8];
    logic [31:0] ev_d [8];
    int          wcnt = 0;
    int          lat  = 0;

    // Reference model of the cache contents
    bit          m_valid [LINES];
    bit          m_dirty [LINES];
    logic [19:0] m_tag   [LINES];
    logic [31:0] m_data  [LINES];

    function automatic logic [31:0] bmem_rd(input int unsigned w);
        if (bmem.exists(w)) return bmem[w];
        return (w * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory with a latency that varies per request
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
            lat = (lat + 1) % 4;
        end else if (mem_rd || mem_wr) begin
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                if (ev_n < 8) begin
                    ev_w[ev_n] = mem_wr;
                    ev_a[ev_n] = mem_addr;
                    ev_d[ev_n] = mem_wr ? mem_wdata : 32'h0;
                end
                ev_n++;
                if (mem_wr) bmem[mem_addr >> 2] = mem_wdata;
                else        mem_rdata = bmem_rd(mem_addr >> 2);
            end else begin
                wcnt++;
            end
        end
    end

    task automatic do_reset();
        cpu_req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LINES; i++) begin
            m_valid[i] = 1'b0;
            m_dirty[i] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic access(input bit we, input logic [31:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd);
        logic [9:0]  idx;
        logic [19:0] tag;
        bit          hit, exp_wb, done;
        logic [31:0] wb_addr, wb_data, exp_data, line_addr;
        int          cyc, exp_n;
        string       rq;
        idx       = addr[11:2];
        tag       = addr[31:12];
        line_addr = {tag, idx, 2'b00};
        hit       = m_valid[idx] && (m_tag[idx] == tag);
        exp_wb    = !hit && m_valid[idx] && m_dirty[idx];
        wb_addr   = {m_tag[idx], idx, 2'b00};
        wb_data   = m_data[idx];
        exp_data  = hit ? m_data[idx] : bmem_rd({tag, idx});
        rq        = hit ? (we ? "R3" : "R2") : (we ? "R5" : "R4");
        m_valid[idx] = 1'b1;
        m_tag[idx]   = tag;
        if (we) begin
            m_data[idx]  = wd;
            m_dirty[idx] = 1'b1;
        end else begin
            m_data[idx] = exp_data;
            if (!hit) m_dirty[idx] = 1'b0;
        end
        while (!cpu_ready) @(negedge clk);
        ev_n = 0;
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        cyc  = 0;
        done = 1'b0;
        while (!done && cyc < 200) begin
            @(posedge clk);
            @(negedge clk);
            if (cyc == 0) cpu_req_valid = 1'b0;
            cyc++;
            chk(!cpu_ready, "R8", "ready low while busy", {31'b0, cpu_ready}, 32'h0);
            chk(!(mem_rd && mem_wr), "R8", "rd and wr together", {31'b0, mem_wr}, 32'h0);
            if (cpu_resp_valid) done = 1'b1;
        end
        rd = cpu_rdata;
        chk(done, "R8", "response arrived", {31'b0, done}, 32'h1);
        if (hit) begin
            chk(ev_n == 0, rq, "memory accesses on hit", ev_n, 0);
            chk(cyc == 2, "R2", "hit latency", cyc, 2);
        end else begin
            exp_n = exp_wb ? 2 : 1;
            chk(ev_n == exp_n, exp_wb ? "R6" : rq, "memory access count", ev_n, exp_n);
            if (exp_wb && ev_n >= 2) begin
                chk(ev_w[0] == 1'b1, "R6", "write-back first", {31'b0, ev_w[0]}, 32'h1);
                chk(ev_a[0] == wb_addr, "R6", "write-back address", ev_a[0], wb_addr);
                chk(ev_d[0] == wb_data, "R6", "write-back data", ev_d[0], wb_data);
            end
            if (ev_n >= 1 && ev_n <= 8) begin
                chk(ev_w[ev_n-1] == 1'b0, rq, "refill is a read", {31'b0, ev_w[ev_n-1]}, 32'h0);
                chk(ev_a[ev_n-1] == line_addr, rq, "refill address", ev_a[ev_n-1], line_addr);
            end
        end
        if (!we) chk(rd == exp_data, rq, "load data", rd, exp_data);
        @(negedge clk);
        chk(!cpu_resp_valid && cpu_ready, "R9", "single response pulse",
            {30'b0, cpu_resp_valid, cpu_ready}, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, lfsr;
        logic [31:0] a_addr, b_addr, c_addr, d_addr;
        a_addr = 32'h0000_1014;  // tag 1, idx 5
        b_addr = 32'h0000_2014;  // tag 2, idx 5
        c_addr = 32'h0000_3040;  // tag 3, idx 16
        d_addr = 32'h0000_5040;  // tag 5, idx 16
        do_reset();
        // R1: idle state after reset
        chk(cpu_ready, "R1", "ready after reset", {31'b0, cpu_ready}, 32'h1);
        chk(!mem_rd && !mem_wr, "R1", "no memory request after reset", {30'b0, mem_rd, mem_wr}, 32'h0);
        chk(!cpu_resp_valid, "R1", "no response after reset", {31'b0, cpu_resp_valid}, 32'h0);

        access(1'b0, a_addr, 32'h0, r);                // R4 cold load miss
        access(1'b0, a_addr, 32'h0, r);                // R2 load hit
        access(1'b1, a_addr, 32'hCAFE_0001, r);        // R3 store hit
        chk(bmem_rd(a_addr >> 2) != 32'hCAFE_0001, "R3", "memory stale after store hit",
            bmem_rd(a_addr >> 2), 32'h0);
        access(1'b0, a_addr + 32'd2, 32'h0, r);        // R7 offset ignored
        chk(r == 32'hCAFE_0001, "R7", "offset alias data", r, 32'hCAFE_0001);
        access(1'b0, b_addr, 32'h0, r);                // R6 dirty victim
        chk(bmem_rd(a_addr >> 2) == 32'hCAFE_0001, "R6", "memory updated by write-back",
            bmem_rd(a_addr >> 2), 32'hCAFE_0001);
        access(1'b0, a_addr, 32'h0, r);                // R6 clean victim, R4 refill clean
        access(1'b1, c_addr, 32'hBEEF_0002, r);        // R5 store miss allocate
        access(1'b0, c_addr, 32'h0, r);                // R5 allocated line hits
        access(1'b1, d_addr, 32'hBEEF_0003, r);        // R5 + R6 store miss on dirty line
        chk(bmem_rd(c_addr >> 2) == 32'hBEEF_0002, "R5", "allocated store written back",
            bmem_rd(c_addr >> 2), 32'hBEEF_0002);
        access(1'b0, 32'h0000_0000, 32'h0, r);         // R7 index 0
        access(1'b1, 32'hFFFF_FFFC, 32'h1234_5678, r); // R7 index 1023, all-ones tag
        access(1'b0, 32'h0000_0001, 32'h0, r);         // R7 index 0 still resident
        access(1'b0, 32'hFFFF_FFFE, 32'h0, r);
        chk(r == 32'h1234_5678, "R7", "top line data", r, 32'h1234_5678);

        do_reset();                                    // R1 all lines invalid again
        access(1'b0, a_addr, 32'h0, r);

        lfsr = 32'hACE1_2345;
        for (int n = 0; n < 80; n++) begin
            logic [31:0] addr;
            lfsr  = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            addr  = {10'b0, 10'(lfsr[5:4] + 1), 10'(lfsr[7:6] == 2'd3 ? 10'd1023 : 10'(lfsr[7:6] + 7)), lfsr[9:8]};
            access(lfsr[10], addr, lfsr ^ 32'h5A5A_0000, r);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule